// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block sits between a load/store pipeline and a single-port synchronous data memory that is 64 bits wide. It carries out one atomic operation per request as a sequence that cannot be broken up. The supported operations are a byte test-and-set, a 32-bit exchange, a 32-bit compare-and-swap and a 64-bit compare-and-swap. Each operation returns the value that memory held before the operation, zero-extended to 64 bits, so the pipeline can write it back to a register.

While a sequence runs, a lock output tells any other requester of the memory to stay off the port. The read, the decision and the optional write therefore happen with nothing in between. The alternate-space forms of the operations use the same datapath. Their only extra effect is that an alternate flag and a space identifier are passed to the memory side.

A request is taken only while the unit is idle. A request with a misaligned address or an unknown opcode is answered with an error flag and never reaches memory.

Top module: `amo_unit`

## Requirements
- R1: After reset, req_ready is 1 and lock, mem_rd, mem_wr and rsp_valid are 0.
- R2: The unit recognises six opcodes, and every other opcode is unsupported:
  - 0x0D: byte test-and-set.
  - 0x0F: exchange.
  - 0x1D: alternate byte test-and-set.
  - 0x1F: alternate exchange.
  - 0x3C: alternate 32-bit compare-and-swap.
  - 0x3E: alternate 64-bit compare-and-swap.

  Memory layout:
  - mem_addr is the byte address shifted right by 3.
  - Byte k of a doubleword occupies bits 8k+7..8k and has strobe mem_be[k], where k is addr[2:0].
  - A 32-bit word occupies bits 31..0 when addr[2] is 0 and bits 63..32 when addr[2] is 1.
  - Each write strobes exactly the bytes of the access.
- R3: Byte test-and-set writes 0xFF to the addressed byte and returns the old byte zero-extended. It writes even when the byte already holds 0xFF.
- R4: Exchange writes req_src[31:0] to the addressed word and returns the old word zero-extended.
- R5: 32-bit compare-and-swap writes req_src[31:0] only when the old word equals req_cmp[31:0]. It always returns the old word.
- R6: 64-bit compare-and-swap writes all 64 bits of req_src only when the old doubleword equals req_cmp. It always returns the old doubleword.
- R7: A compare-and-swap whose comparison fails issues no write strobe. Its response comes 3 cycles after acceptance instead of 4.
- R8: During the memory accesses, mem_alt is 1 for the alternate opcodes (0x1D, 0x1F, 0x3C, 0x3E) and 0 for the plain ones, and mem_asi equals the req_asi captured at acceptance. Apart from this, alternate forms behave exactly like the plain forms.
- R9: A request whose address is not aligned to its access size is answered with rsp_align_err = 1 and rsp_data = 0 one cycle after acceptance. It makes no memory access and does not assert lock.
- R10: An unsupported opcode is answered with rsp_bad_op = 1 and rsp_data = 0 one cycle after acceptance. It makes no memory access.
- R11: lock is 1 in the read cycle, in the compare cycle and in the write cycle (when there is one), and 0 at all other times.
- R12: rsp_valid is a single-cycle pulse. req_ready is 1 only while idle, so no request is taken during a sequence.
- R13: The memory read is issued in the cycle after acceptance. The write, when there is one, follows the read by two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; a request is taken at this edge |
| req_op | input | 6 | Operation code |
| req_addr | input | ADDR_W | Byte address |
| req_asi | input | ASI_W | Address space identifier for alternate forms |
| req_src | input | 64 | Register source value (store data) |
| req_cmp | input | 64 | Compare operand |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 64 | Old memory value, zero-extended |
| rsp_align_err | output | 1 | Misaligned request (qualified by rsp_valid) |
| rsp_bad_op | output | 1 | Unsupported opcode (qualified by rsp_valid) |
| lock | output | 1 | Holds other requesters off the memory |
| mem_rd | output | 1 | Memory read strobe; data returns on the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_be | output | 8 | Byte strobes for the write |
| mem_addr | output | ADDR_W-3 | Doubleword index |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, registered by the memory |
| mem_alt | output | 1 | Alternate-space access |
| mem_asi | output | ASI_W | Space identifier passed through |

## Verification
The hardest case to reach from the ports is a compare-and-swap whose compare value matches memory. Random compare values almost never match. For this reason the stimulus copies the model's current contents of the target word into the compare operand for half of the compare-and-swap requests, and a random value into the other half. Each random request is issued at the same edge at which the previous response ends, so operations follow one another with no gap. Directed cases add a test-and-set on a byte that already holds 0xFF, misaligned words and doublewords, and an unknown opcode.

// File: rtl/amo_pkg.sv
package amo_pkg;
   localparam int DW = 64;
   localparam int NB = DW / 8;

   localparam logic [5:0] OPC_TAS       = 6'h0D;
   localparam logic [5:0] OPC_XCHG      = 6'h0F;
   localparam logic [5:0] OPC_TAS_ALT   = 6'h1D;
   localparam logic [5:0] OPC_XCHG_ALT  = 6'h1F;
   localparam logic [5:0] OPC_CAS32_ALT = 6'h3C;
   localparam logic [5:0] OPC_CAS64_ALT = 6'h3E;

   typedef enum logic [1:0] {K_TAS, K_XCHG, K_CAS, K_BAD} kind_t;
   typedef enum logic [1:0] {SZ_B, SZ_W, SZ_D} size_t;
   typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_MOD, ST_WRITE, ST_DONE} state_t;

   typedef struct packed {
      kind_t kind;
      size_t size;
      logic  alt;
   } opinfo_t;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
   import amo_pkg::*;
(
   input  logic [5:0] op,
   input  logic [2:0] addr_lo,
   output opinfo_t    info,
   output logic       bad,
   output logic       misalign
);
   always_comb begin
      unique case (op)
         OPC_TAS:       info = '{K_TAS,  SZ_B, 1'b0};
         OPC_XCHG:      info = '{K_XCHG, SZ_W, 1'b0};
         OPC_TAS_ALT:   info = '{K_TAS,  SZ_B, 1'b1};
         OPC_XCHG_ALT:  info = '{K_XCHG, SZ_W, 1'b1};
         OPC_CAS32_ALT: info = '{K_CAS,  SZ_W, 1'b1};
         OPC_CAS64_ALT: info = '{K_CAS,  SZ_D, 1'b1};
         default:       info = '{K_BAD,  SZ_B, 1'b0};
      endcase
   end

   assign bad      = (info.kind == K_BAD);
   assign misalign = !bad &&
                     (((info.size == SZ_W) && (addr_lo[1:0] != 2'b00)) ||
                      ((info.size == SZ_D) && (addr_lo != 3'b000)));
endmodule

// File: rtl/amo_lane.sv
module amo_lane
   import amo_pkg::*;
(
   input  logic [DW-1:0] rdata,
   input  logic [2:0]    lane,
   input  size_t         size,
   input  kind_t         kind,
   input  logic [DW-1:0] src,
   input  logic [DW-1:0] cmp,
   output logic [DW-1:0] old_val,
   output logic          match,
   output logic [NB-1:0] be,
   output logic [DW-1:0] wdata
);
   logic [7:0]  rb [NB];
   logic [31:0] rword;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      localparam logic [2:0] IDX  = 3'(i);
      localparam int         WOFF = (i % 4) * 8;
      assign rb[i] = rdata[8*i +: 8];
      assign be[i] = (size == SZ_B) ? (lane == IDX) :
                     (size == SZ_W) ? (lane[2] == IDX[2]) : 1'b1;
      assign wdata[8*i +: 8] = (kind == K_TAS) ? 8'hFF :
                               (size == SZ_W)  ? src[WOFF +: 8] : src[8*i +: 8];
   end

   assign rword = lane[2] ? rdata[63:32] : rdata[31:0];

   always_comb begin
      unique case (size)
         SZ_B:    old_val = {{(DW-8){1'b0}}, rb[lane]};
         SZ_W:    old_val = {{(DW-32){1'b0}}, rword};
         default: old_val = rdata;
      endcase
      match = (size == SZ_D) ? (rdata == cmp) : (rword == cmp[31:0]);
   end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
   import amo_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   early_err,
   input  logic   need_write,
   output state_t state
);
   state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (start) nxt = early_err ? ST_DONE : ST_READ;
         ST_READ:  nxt = ST_MOD;
         ST_MOD:   nxt = need_write ? ST_WRITE : ST_DONE;
         ST_WRITE: nxt = ST_DONE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int ASI_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [5:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ASI_W-1:0]  req_asi,
   input  logic [DW-1:0]     req_src,
   input  logic [DW-1:0]     req_cmp,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_data,
   output logic              rsp_align_err,
   output logic              rsp_bad_op,
   output logic              lock,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [NB-1:0]     mem_be,
   output logic [ADDR_W-4:0] mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   output logic              mem_alt,
   output logic [ASI_W-1:0]  mem_asi
);
   localparam int MA_W = ADDR_W - 3;

   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("amo_unit: ADDR_W must be at least 4");
   end
   if (ASI_W < 1) begin : g_bad_asi_w
      $error("amo_unit: ASI_W must be at least 1");
   end

   state_t            state;
   opinfo_t           dec_info, info_q;
   logic              dec_bad, dec_mis;
   logic              bad_q, mis_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ASI_W-1:0]  asi_q;
   logic [DW-1:0]     src_q, cmp_q, old_q, old_val;
   logic              match, start, need_write;

   amo_decode u_dec (
      .op       (req_op),
      .addr_lo  (req_addr[2:0]),
      .info     (dec_info),
      .bad      (dec_bad),
      .misalign (dec_mis)
   );

   assign start = req_valid && (state == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         info_q <= '{K_BAD, SZ_B, 1'b0};
         bad_q  <= 1'b0;
         mis_q  <= 1'b0;
         addr_q <= '0;
         asi_q  <= '0;
         src_q  <= '0;
         cmp_q  <= '0;
         old_q  <= '0;
      end else if (start) begin
         info_q <= dec_info;
         bad_q  <= dec_bad;
         mis_q  <= dec_mis;
         addr_q <= req_addr;
         asi_q  <= req_asi;
         src_q  <= req_src;
         cmp_q  <= req_cmp;
         old_q  <= '0;
      end else if (state == ST_MOD) begin
         old_q  <= old_val;
      end
   end

   amo_lane u_lane (
      .rdata   (mem_rdata),
      .lane    (addr_q[2:0]),
      .size    (info_q.size),
      .kind    (info_q.kind),
      .src     (src_q),
      .cmp     (cmp_q),
      .old_val (old_val),
      .match   (match),
      .be      (mem_be),
      .wdata   (mem_wdata)
   );

   assign need_write = (info_q.kind != K_CAS) || match;

   amo_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .early_err  (dec_bad || dec_mis),
      .need_write (need_write),
      .state      (state)
   );

   assign req_ready     = (state == ST_IDLE);
   assign mem_rd        = (state == ST_READ);
   assign mem_wr        = (state == ST_WRITE);
   assign lock          = mem_rd || mem_wr || (state == ST_MOD);
   assign mem_addr      = addr_q[ADDR_W-1 -: MA_W];
   assign mem_alt       = info_q.alt;
   assign mem_asi       = asi_q;
   assign rsp_valid     = (state == ST_DONE);
   assign rsp_data      = old_q;
   assign rsp_align_err = rsp_valid && mis_q;
   assign rsp_bad_op    = rsp_valid && bad_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       rsp_valid,
   input logic       rsp_align_err,
   input logic       rsp_bad_op,
   input logic       lock,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic [7:0] mem_be
);
   // R11
   rd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> lock);
   // R11
   wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> lock);
   // R13
   rd_then_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (lock && !mem_rd && !mem_wr));
   // R13
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd, 2));
   // R12
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R12
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R9
   err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_align_err || rsp_bad_op)) |-> ($past(req_valid && req_ready) && !lock));
   // R2
   strobe_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($countones(mem_be) == 1 || $countones(mem_be) == 4 || $countones(mem_be) == 8));
   // R12
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, rsp_valid}));
endmodule

bind amo_unit amo_unit_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_align_err (rsp_align_err),
   .rsp_bad_op    (rsp_bad_op),
   .lock          (lock),
   .mem_rd        (mem_rd),
   .mem_wr        (mem_wr),
   .mem_be        (mem_be)
);

// File: tb/amo_unit_bench.sv
`timescale 1ns/1ps
module amo_unit_bench;
   localparam int AW = 8;
   localparam int SW = 8;
   localparam int NW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [5:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_asi = '0;
   logic [63:0]   req_src = '0, req_cmp = '0;
   logic          rsp_valid, rsp_align_err, rsp_bad_op, lock;
   logic          mem_rd, mem_wr, mem_alt;
   logic [7:0]    mem_be;
   logic [AW-4:0] mem_addr;
   logic [63:0]   mem_wdata, mem_rdata;
   logic [SW-1:0] mem_asi;

   logic [63:0] ram [NW];
   logic [63:0] ref_mem [NW];
   int errors = 0, checks = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   amo_unit #(.ADDR_W(AW), .ASI_W(SW)) u_amo_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_asi(req_asi),
      .req_src(req_src), .req_cmp(req_cmp), .rsp_valid(rsp_valid),
      .rsp_data(), .rsp_align_err(rsp_align_err), .rsp_bad_op(rsp_bad_op),
      .lock(lock), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_alt(mem_alt), .mem_asi(mem_asi)
   );
   wire [63:0] rsp_data = u_amo_unit.rsp_data;

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= ram[mem_addr];
      if (mem_wr)
         for (int i = 0; i < 8; i++)
            if (mem_be[i]) ram[mem_addr][8*i +: 8] <= mem_wdata[8*i +: 8];
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // independent reference model of one operation
   task automatic model(input [5:0] op, input [AW-1:0] a, input [63:0] src,
                        input [63:0] cmp, input [63:0] m,
                        output [63:0] old, output [63:0] nm,
                        output bit bad, output bit mis, output bit wr, output bit alt);
      int sh;
      logic [63:0] wm;
      bad = 0; mis = 0; wr = 0; alt = 0; old = 0; nm = m;
      case (op)
         6'h0D, 6'h1D: begin
            alt = (op == 6'h1D);
            sh = 8 * a[2:0];
            old = (m >> sh) & 64'hFF;
            nm = m | (64'hFF << sh); wr = 1;
         end
         6'h0F, 6'h1F, 6'h3C: begin
            alt = (op != 6'h0F);
            if (a[1:0] != 0) mis = 1;
            else begin
               sh = 32 * a[2];
               wm = 64'hFFFF_FFFF << sh;
               old = (m >> sh) & 64'hFFFF_FFFF;
               wr = (op != 6'h3C) || (old == {32'h0, cmp[31:0]});
               if (wr) nm = (m & ~wm) | (({32'h0, src[31:0]} << sh) & wm);
            end
         end
         6'h3E: begin
            alt = 1;
            if (a[2:0] != 0) mis = 1;
            else begin
               old = m; wr = (m == cmp);
               if (wr) nm = src;
            end
         end
         default: bad = 1;
      endcase
      if (bad || mis) old = 0;
   endtask

   task automatic run_op(input [5:0] op, input [AW-1:0] a, input [SW-1:0] asi,
                         input [63:0] src, input [63:0] cmp, input string tag);
      logic [63:0] eold, enew;
      bit ebad, emis, ewr, ealt;
      int idx, cyc, nrd, nwr, nlock, nready;
      logic alt_seen, asi_ok;
      idx = a[AW-1:3];
      model(op, a, src, cmp, ref_mem[idx], eold, enew, ebad, emis, ewr, ealt);
      req_op = op; req_addr = a; req_asi = asi; req_src = src; req_cmp = cmp;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1; nrd = 0; nwr = 0; nlock = 0; nready = 0; alt_seen = 0; asi_ok = 1;
      while (!rsp_valid && cyc < 12) begin
         nrd += mem_rd; nwr += mem_wr; nlock += lock; nready += req_ready;
         if (mem_rd || mem_wr) begin
            alt_seen = mem_alt;
            if (mem_asi != asi) asi_ok = 0;
         end
         @(negedge clk);
         cyc++;
      end
      chk(rsp_valid, {tag, " R12"}, "response seen", 64'(rsp_valid), 1);
      chk(rsp_data == eold, tag, "old value", rsp_data, eold);
      chk(rsp_align_err == emis, {tag, " R9"}, "align flag", 64'(rsp_align_err), 64'(emis));
      chk(rsp_bad_op == ebad, {tag, " R10"}, "bad-op flag", 64'(rsp_bad_op), 64'(ebad));
      chk(ram[idx] == enew, tag, "memory contents", ram[idx], enew);
      chk(nwr == 64'(ewr), {tag, " R7"}, "write strobes", 64'(nwr), 64'(ewr));
      chk(nrd == ((ebad || emis) ? 0 : 1), {tag, " R13"}, "read strobes", 64'(nrd),
          (ebad || emis) ? 0 : 1);
      chk(cyc == ((ebad || emis) ? 1 : (ewr ? 4 : 3)), {tag, " R13"}, "latency",
          64'(cyc), (ebad || emis) ? 1 : (ewr ? 4 : 3));
      chk(nlock == ((ebad || emis) ? 0 : (ewr ? 3 : 2)), {tag, " R11"}, "lock cycles",
          64'(nlock), (ebad || emis) ? 0 : (ewr ? 3 : 2));
      chk(nready == 0 && !lock, {tag, " R12"}, "ready low while busy", 64'(nready), 0);
      if (!(ebad || emis)) begin
         chk(alt_seen == ealt, {tag, " R8"}, "alt flag", 64'(alt_seen), 64'(ealt));
         chk(asi_ok, {tag, " R8"}, "asi passthrough", 64'(asi_ok), 1);
      end
      ref_mem[idx] = enew;
   endtask

   initial begin
      logic [5:0] ops [7];
      void'($urandom(32'd4711));
      ops = '{6'h0D, 6'h0F, 6'h1D, 6'h1F, 6'h3C, 6'h3E, 6'h2A};
      for (int i = 0; i < NW; i++) begin
         ram[i] = {$urandom, $urandom};
         ref_mem[i] = ram[i];
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready && !lock && !mem_rd && !mem_wr && !rsp_valid, "R1", "reset outputs",
          {59'h0, req_ready, lock, mem_rd, mem_wr, rsp_valid}, 64'h10);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: test-and-set on a byte already 0xFF, and on a plain byte
      ram[2] = 64'h0000_FF00_0000_0000; ref_mem[2] = ram[2];
      run_op(6'h0D, 8'h15, 8'h00, 64'h0, 64'h0, "R3 tas-ff");
      run_op(6'h1D, 8'h13, 8'h5A, 64'h0, 64'h0, "R3 tas-alt");
      // R4 exchange, both halves
      run_op(6'h0F, 8'h24, 8'h00, 64'hAAAA_BBBB_1234_5678, 64'h0, "R4 xchg-hi");
      run_op(6'h1F, 8'h20, 8'h77, 64'h0000_0000_CAFE_F00D, 64'h0, "R4 xchg-lo-alt");
      // R5 cas32 success and failure
      run_op(6'h3C, 8'h30, 8'h11, 64'h9999_0000_1111_2222, {32'hDEAD, ref_mem[6][31:0]}, "R5 cas32-hit");
      run_op(6'h3C, 8'h34, 8'h11, 64'h3333_4444, ~{32'h0, ref_mem[6][63:32]}, "R5 cas32-miss");
      // R6 cas64 success and failure
      run_op(6'h3E, 8'h40, 8'h22, 64'h0123_4567_89AB_CDEF, ref_mem[8], "R6 cas64-hit");
      run_op(6'h3E, 8'h40, 8'h22, 64'h0, ref_mem[8] ^ 64'h1, "R6 cas64-miss");
      // R9 misaligned, R10 unsupported opcode
      run_op(6'h0F, 8'h22, 8'h00, 64'h5, 64'h0, "R9 word-mis");
      run_op(6'h3E, 8'h44, 8'h00, 64'h5, 64'h5, "R9 dword-mis");
      run_op(6'h00, 8'h48, 8'h00, 64'h5, 64'h5, "R10 bad-op");

      // R2 random mix, issued back to back
      for (int n = 0; n < 400; n++) begin
         logic [5:0]    op;
         logic [AW-1:0] a;
         logic [63:0]   cmpv, m;
         op = ops[$urandom_range(6)];
         a = AW'($urandom);
         if ($urandom_range(3) != 0) begin
            if (op == 6'h3E) a[2:0] = 3'b000;
            else if (op != 6'h0D && op != 6'h1D) a[1:0] = 2'b00;
         end
         m = ref_mem[a[AW-1:3]];
         cmpv = {$urandom, $urandom};
         if ($urandom_range(1) == 1)
            cmpv = (op == 6'h3E) ? m : {32'h0, (a[2] ? m[63:32] : m[31:0])};
         run_op(op, a, SW'($urandom), {$urandom, $urandom}, cmpv, "R2 random");
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog R12: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule